// File: doc/BRIEF.md
# Two-Stage PLL and System Reset Sequencer

This block orders reset release on a chip that runs from an external reference clock through a PLL and that has a push-button reset. After configuration both of its outputs are high. A first delay chain, clocked by the external clock, keeps the PLL in reset for a fixed number of reference cycles and then lets it go. The system reset stays high until three conditions hold together: the PLL reset is released, the PLL reports lock, and the button is not pressed.

Once those conditions hold, the lock and button state pass through a two-flop synchronizer in the PLL clock domain. A second delay chain, clocked by the PLL output, then counts a fixed number of PLL cycles before it drops the system reset. If lock is lost or the button is pressed, the system reset goes high at once, without waiting for a clock edge. The release delay then starts again from the beginning. Both delays are shift registers filled with ones that drain zeros, not binary counters.

Top module: `twoStageResetSeq`

## Requirements
- R1: From configuration, before any clock edge, both `pllRstOut` and `sysRstOut` are 1 (active high).
- R2: `pllRstOut` stays 1 through the first PLL_STAGES-1 rising edges of `extClk`, goes to 0 on edge PLL_STAGES, and stays 0 afterwards.
- R3: `sysRstOut` is 1 whenever `pllRstOut` is 1.
- R4: `sysRstOut` stays 1 for as long as `pllLocked` is 0, however long that lasts.
- R5: `sysRstOut` stays 1 for as long as `buttonPressed` is 1, however long that lasts.
- R6: If `pllRstOut` is 0, `pllLocked` is 1 and `buttonPressed` is 0 from some point onward, `sysRstOut` stays 1 through the next SYS_STAGES+1 rising edges of `pllClk` and is 0 after edge SYS_STAGES+2. The two extra edges are the synchronizer.
- R7: When `pllLocked` falls, `sysRstOut` goes to 1 with no `pllClk` edge in between.
- R8: A press of `buttonPressed` sets `sysRstOut` to 1 with no clock edge, even a press shorter than one PLL cycle. A press during a partly finished release delay restarts the full R6 delay, counted from the end of the press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| extClk | input | 1 | External reference clock; clocks the PLL-reset chain |
| pllClk | input | 1 | PLL output clock; clocks the system-reset chain |
| pllLocked | input | 1 | 1 when the PLL reports lock (asynchronous) |
| buttonPressed | input | 1 | 1 while the push-button reset is held (asynchronous) |
| pllRstOut | output | 1 | Reset to the PLL, active high |
| sysRstOut | output | 1 | Reset to the rest of the chip, active high |

## Verification
The release-timing property assumes that `pllLocked` and `buttonPressed` do not change within the setup window of a `pllClk` edge, so that the synchronizer's first flop never samples a changing value. The hold properties compare the raw inputs with the output at PLL edges, which relies on the asynchronous set taking effect in the same time step as the input change. The stimulus changes lock and button only on falling `pllClk` edges, or one time unit after them. It never moves either input near a rising edge, and it runs the two clocks at unrelated periods so that the end of the PLL reset drifts across the PLL clock phase.

// File: rtl/rsqPkg.sv
package rsqPkg;
  // strobes from the control half to the delay chains
  typedef struct packed {
    logic hold;     // force the chain full (reset asserted)
    logic advance;  // drain one stage this edge
  } rsqStrobes_t;
endpackage

// File: rtl/rsqChain.sv
module rsqChain
  import rsqPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter bit ASYNC_SET = 1'b0
) (
  input  logic        clk,
  input  rsqStrobes_t strb,
  output logic        rstOut
);
  localparam int MSB = DEPTH - 1;

  logic [MSB:0] chain = '1;

  generate
    if (ASYNC_SET) begin : g_async
      always_ff @(posedge clk or posedge strb.hold) begin
        if (strb.hold)         chain <= '1;
        else if (strb.advance) chain <= {chain[MSB-1:0], 1'b0};
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (strb.hold)         chain <= '1;
        else if (strb.advance) chain <= {chain[MSB-1:0], 1'b0};
      end
    end
  endgenerate

  assign rstOut = chain[MSB];
endmodule

// File: rtl/rsqCtrl.sv
module rsqCtrl
  import rsqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        pllClk,
  input  logic        pllLocked,
  input  logic        buttonPressed,
  input  logic        pllRstIn,
  output rsqStrobes_t refStrb,
  output rsqStrobes_t sysStrb
);
  localparam int SMSB = SYNC_STAGES - 1;

  logic holdReq;
  logic [SMSB:0] okSync = '0;

  // any of these forces the system chain full, without a clock
  assign holdReq = pllRstIn | ~pllLocked | buttonPressed;

  always_ff @(posedge pllClk or posedge holdReq) begin
    if (holdReq) okSync <= '0;
    else         okSync <= {okSync[SMSB-1:0], 1'b1};
  end

  // reference chain drains freely from configuration
  assign refStrb.hold    = 1'b0;
  assign refStrb.advance = 1'b1;

  assign sysStrb.hold    = holdReq;
  assign sysStrb.advance = okSync[SMSB];
endmodule

// File: rtl/rsqDatapath.sv
module rsqDatapath
  import rsqPkg::*;
#(
  parameter int PLL_STAGES = 16,
  parameter int SYS_STAGES = 16
) (
  input  logic        extClk,
  input  logic        pllClk,
  input  rsqStrobes_t refStrb,
  input  rsqStrobes_t sysStrb,
  output logic        pllRst,
  output logic        sysRst
);
  rsqChain #(.DEPTH(PLL_STAGES), .ASYNC_SET(1'b0)) u_refChain (
    .clk(extClk), .strb(refStrb), .rstOut(pllRst));

  rsqChain #(.DEPTH(SYS_STAGES), .ASYNC_SET(1'b1)) u_sysChain (
    .clk(pllClk), .strb(sysStrb), .rstOut(sysRst));
endmodule

// File: rtl/twoStageResetSeq.sv
module twoStageResetSeq
  import rsqPkg::*;
#(
  parameter int PLL_STAGES = 16,
  parameter int SYS_STAGES = 16
) (
  input  logic extClk,
  input  logic pllClk,
  input  logic pllLocked,
  input  logic buttonPressed,
  output logic pllRstOut,
  output logic sysRstOut
);
  rsqStrobes_t refStrb;
  rsqStrobes_t sysStrb;
  logic        pllRst;
  logic        sysRst;

  rsqCtrl #(.SYNC_STAGES(2)) u_ctrl (
    .pllClk(pllClk), .pllLocked(pllLocked), .buttonPressed(buttonPressed),
    .pllRstIn(pllRst), .refStrb(refStrb), .sysStrb(sysStrb));

  rsqDatapath #(.PLL_STAGES(PLL_STAGES), .SYS_STAGES(SYS_STAGES)) u_dp (
    .extClk(extClk), .pllClk(pllClk), .refStrb(refStrb), .sysStrb(sysStrb),
    .pllRst(pllRst), .sysRst(sysRst));

  assign pllRstOut = pllRst;
  assign sysRstOut = sysRst;
endmodule

// File: rtl/rsqChecker.sv
module rsqChecker (
  input logic extClk,
  input logic pllClk,
  input logic pllLocked,
  input logic buttonPressed,
  input logic pllRstOut,
  input logic sysRstOut
);
  // history guards: enough edges seen for $past to be meaningful
  logic       extSeen = 1'b0;
  logic [1:0] pllSeen = 2'd0;

  always_ff @(posedge extClk) extSeen <= 1'b1;
  always_ff @(posedge pllClk) if (pllSeen != 2'd3) pllSeen <= pllSeen + 2'd1;

  // R2: once released, the PLL reset never comes back
  p_pll_stays_low_r2: assert property (@(posedge extClk) disable iff (!extSeen)
    !pllRstOut |=> !pllRstOut);

  // R3: system reset covers the whole PLL reset
  p_order_r3: assert property (@(posedge pllClk) disable iff (pllSeen == 2'd0)
    pllRstOut |-> sysRstOut);

  // R4: no lock, no release
  p_lock_hold_r4: assert property (@(posedge pllClk) disable iff (pllSeen == 2'd0)
    !pllLocked |-> sysRstOut);

  // R5: button held keeps reset
  p_button_hold_r5: assert property (@(posedge pllClk) disable iff (pllSeen == 2'd0)
    buttonPressed |-> sysRstOut);

  // R6: a release is preceded by good inputs through the synchronizer
  p_release_sync_r6: assert property (@(posedge pllClk) disable iff (pllSeen != 2'd3)
    $fell(sysRstOut) |-> ($past(pllLocked && !buttonPressed, 1) &&
                          $past(pllLocked && !buttonPressed, 2) &&
                          !$past(pllRstOut, 1)));
endmodule

bind twoStageResetSeq rsqChecker u_chk (
  .extClk(extClk), .pllClk(pllClk), .pllLocked(pllLocked),
  .buttonPressed(buttonPressed), .pllRstOut(pllRstOut), .sysRstOut(sysRstOut));

// File: tb/twoStageResetSeq_tb.sv
module twoStageResetSeq_tb;
  localparam int CLK_PERIOD = 10;   // external clock
  localparam int PLL_PERIOD = 6;    // PLL output clock
  localparam int PLL_N = 5;
  localparam int SYS_N = 7;

  logic extClk = 1'b0;
  logic pllClk = 1'b0;
  logic pllLocked = 1'b1;
  logic buttonPressed = 1'b0;
  logic pllRstOut;
  logic sysRstOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) extClk = ~extClk;
  always #(PLL_PERIOD/2) pllClk = ~pllClk;

  twoStageResetSeq #(.PLL_STAGES(PLL_N), .SYS_STAGES(SYS_N)) u_dut (
    .extClk(extClk), .pllClk(pllClk), .pllLocked(pllLocked),
    .buttonPressed(buttonPressed), .pllRstOut(pllRstOut), .sysRstOut(sysRstOut));

  task automatic check(string req, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  // R1: configuration state
  task automatic testConfig();
    #1;
    check("R1 pll", pllRstOut, 1'b1);
    check("R1 sys", sysRstOut, 1'b1);
  endtask

  // R2 and R3: PLL reset length, system reset covering it (lock already high)
  task automatic testPllStage();
    for (int k = 1; k < PLL_N; k++) begin
      @(negedge extClk);
      check("R2 held", pllRstOut, 1'b1);
      check("R3 sys covers pll", sysRstOut, 1'b1);
    end
    @(negedge extClk);
    check("R2 released", pllRstOut, 1'b0);
    for (int k = 0; k < SYS_N + 3; k++) @(negedge pllClk);
    check("R3 sys released after pll", sysRstOut, 1'b0);
  endtask

  // R6: release exactly SYS_N+2 PLL edges after inputs settle (just before a negedge)
  task automatic expectRelease(string req);
    for (int k = 1; k <= SYS_N + 1; k++) begin
      @(negedge pllClk);
      check(req, sysRstOut, 1'b1);
    end
    @(negedge pllClk);
    check(req, sysRstOut, 1'b0);
  endtask

  // R7, R4, R6: lock loss
  task automatic testLockLoss();
    @(negedge pllClk);
    pllLocked = 1'b0;
    #1;
    check("R7 async on lock loss", sysRstOut, 1'b1);
    for (int k = 0; k < 40; k++) begin
      @(negedge pllClk);
      check("R4 held while unlocked", sysRstOut, 1'b1);
    end
    pllLocked = 1'b1;
    expectRelease("R6 delay after lock");
  endtask

  // R5, R8: long press
  task automatic testButtonHeld();
    @(negedge pllClk);
    buttonPressed = 1'b1;
    #1;
    check("R8 async on press", sysRstOut, 1'b1);
    for (int k = 0; k < 30; k++) begin
      @(negedge pllClk);
      check("R5 held while pressed", sysRstOut, 1'b1);
    end
    buttonPressed = 1'b0;
    expectRelease("R6 delay after button");
  endtask

  // R8: short press in the middle of a release delay restarts it
  task automatic testRestart();
    @(negedge pllClk);
    pllLocked = 1'b0;
    @(negedge pllClk);
    pllLocked = 1'b1;
    for (int k = 0; k < SYS_N / 2 + 2; k++) @(negedge pllClk);
    check("R8 mid-delay still held", sysRstOut, 1'b1);
    buttonPressed = 1'b1;
    #1;
    check("R8 short press asserts", sysRstOut, 1'b1);
    buttonPressed = 1'b0;
    expectRelease("R8 full delay restarted");
    check("R2 pll stays released", pllRstOut, 1'b0);
  endtask

  initial begin
    testConfig();
    testPllStage();
    testLockLoss();
    testButtonHeld();
    testRestart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule